// File: doc/BRIEF.md
# Interrupt Redirection Service Engine

This block turns interrupt input activity into message-signalled interrupt writes. It keeps a table of 24 redirection entries and a pending-request register, one bit per pin. Each entry gives a pin its vector, delivery mode, destination, trigger type and mask. Input levels are sampled every cycle. Edge pins latch a request on a rising input. Level pins follow their input. Level pins also carry a remote-request flag that holds back further deliveries until the end-of-interrupt logic clears the flag.

Each delivered pin produces one address/data pair on a valid/ready output port. The message address is a fixed base combined with the entry's 16-bit destination field and its destination-mode bit. The message data combines the vector, the delivery mode and the trigger type. Entries are written and read 32 bits at a time through a simple register-access port. A separate per-pin clear input lets the end-of-interrupt logic drop remote-request flags, and a cleared pin is serviced again if it is still asserted. When an entry selects the external-controller delivery mode, the vector is taken from a dedicated input port.

Top module: `irq_redir_engine`

## Requirements
- R1: After reset every entry reads back with only the mask bit (bit 16) set, no request is pending and `msg_valid` is low.
- R2: Input line 0 drives pin 2 together with input line 2. Pin 0 is never driven. Input lines numbered 24 and above have no effect.
- R3: On a level pin (trigger bit 15 = 1) the pending bit follows the input. Delivery happens only while remote-request (entry bit 14) is clear. Each delivery sets remote-request, which reads back as bit 14, and at most one such flag is set per cycle.
- R4: On an edge pin (trigger bit 15 = 0) a rising input is recorded only while mask (bit 16) is clear. A rising input on a masked edge pin is discarded, so unmasking the pin later sends nothing.
- R5: Delivering an edge pin clears its pending bit. A single rising edge yields exactly one message, however long the input stays high.
- R6: A pending pin that is masked sends no message and stays pending. Clearing its mask then delivers it.
- R7: `msg_addr` = 0xFEE00000 OR (destination field bits 63:48 shifted left by 4) OR (destination-mode bit 11 shifted left by 2).
- R8: `msg_data` = vector in bits 7:0, delivery mode (entry bits 10:8) in bits 10:8, trigger bit in bit 15, and zero in all other bits.
- R9: When the delivery mode is 3'b111, the data vector is `ext_vector` instead of entry bits 7:0.
- R10: Among eligible pins the lowest number is sent first, and at most one message is loaded per cycle. While `msg_valid` is high and `msg_ready` is low, the message stays unchanged.
- R11: A high bit of `rirr_clr` clears that pin's remote-request flag, and the pin is delivered again if its input is still asserted. If a clear and a delivery of the same pin fall in the same cycle, the flag ends up set.
- R12: A write selects the upper (`cfg_hi`=1) or lower 32-bit half of the entry at `cfg_idx`. Bits 12 and 14 ignore writes: bit 12 reads 0 and bit 14 reads the remote-request flag. Any entry whose trigger bit is 0 after a write has its remote-request flag cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 32 | Interrupt input levels |
| cfg_we | input | 1 | Entry half write strobe |
| cfg_hi | input | 1 | Selects the upper 32 bits of the entry |
| cfg_idx | input | 5 | Entry index for write and read |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected half |
| rirr_clr | input | 24 | Per-pin remote-request clear from end-of-interrupt logic |
| ext_vector | input | 8 | Vector used for the external-controller delivery mode |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Message consumer accepts |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The critical collision is an end-of-interrupt clear and a fresh delivery of the same level pin landing in the same cycle: the delivery sets the remote-request flag while the clear tries to drop it. The bench raises a level input and times a one-cycle clear pulse to the exact cycle in which the pin is loaded into the message slot. It then expects the flag to read back as set and no second message to follow until a later clear arrives. A behavioural reference model checks every cycle of this and all other sequences, including table writes that flip the trigger type while a flag is set.

// File: rtl/irq_redir_engine.sv
module irq_redir_engine #(
  parameter int NPINS     = 24,
  parameter int NIN       = 32,
  parameter int REMAP_PIN = 2,
  parameter logic [31:0] MSG_BASE = 32'hFEE0_0000,
  parameter int IDXW      = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIN-1:0]   irq_lines,
  input  logic             cfg_we,
  input  logic             cfg_hi,
  input  logic [IDXW-1:0]  cfg_idx,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic [NPINS-1:0] rirr_clr,
  input  logic [7:0]       ext_vector,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [31:0]      msg_addr,
  output logic [31:0]      msg_data
);
  localparam int BIT_DMODE = 11;
  localparam int BIT_RIRR  = 14;
  localparam int BIT_TRIG  = 15;
  localparam int BIT_MASK  = 16;
  localparam logic [31:0] RO_LO   = 32'h0000_5000;
  localparam logic [63:0] ENT_RST = 64'd1 << BIT_MASK;
  localparam logic [2:0]  DM_EXT  = 3'b111;

  logic [63:0]      ent_q [NPINS];
  logic [NPINS-1:0] irr_q, rirr_q, prev_q;
  logic [NPINS-1:0] pin_lvl, rise, trig_v, mask_v, trig_nx, elig, take;
  logic [IDXW-1:0]  sel;
  logic             found, load;
  logic [63:0]      sel_ent;
  logic [7:0]       vec;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    if (p == 0) begin : g_none
      assign pin_lvl[p] = 1'b0;
    end else if (p == REMAP_PIN) begin : g_remap
      assign pin_lvl[p] = irq_lines[p] | irq_lines[0];
    end else if (p < NIN) begin : g_direct
      assign pin_lvl[p] = irq_lines[p];
    end else begin : g_absent
      assign pin_lvl[p] = 1'b0;
    end
    assign trig_v[p]  = ent_q[p][BIT_TRIG];
    assign mask_v[p]  = ent_q[p][BIT_MASK];
    assign elig[p]    = irr_q[p] & ~mask_v[p] & ~(trig_v[p] & rirr_q[p]);
    assign trig_nx[p] = (cfg_we && !cfg_hi && cfg_idx == IDXW'(p)) ?
                        cfg_wdata[BIT_TRIG] : trig_v[p];
  end

  if (NIN > NPINS) begin : g_spare
    logic unused_spare;
    assign unused_spare = |irq_lines[NIN-1:NPINS];
  end

  assign rise = pin_lvl & ~prev_q;

  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int p = NPINS - 1; p >= 0; p--) begin
      if (elig[p]) begin
        sel   = IDXW'(p);
        found = 1'b1;
      end
    end
  end

  assign load    = found & (~msg_valid | msg_ready);
  assign take    = load ? (NPINS'(1) << sel) : '0;
  assign sel_ent = ent_q[sel];
  assign vec     = (sel_ent[10:8] == DM_EXT) ? ext_vector : sel_ent[7:0];

  always_comb begin
    cfg_rdata = '0;
    for (int p = 0; p < NPINS; p++) begin
      if (cfg_idx == IDXW'(p))
        cfg_rdata = cfg_hi ? ent_q[p][63:32]
                           : (ent_q[p][31:0] | (32'(rirr_q[p]) << BIT_RIRR));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPINS; p++) ent_q[p] <= ENT_RST;
    end else if (cfg_we) begin
      for (int p = 0; p < NPINS; p++) begin
        if (cfg_idx == IDXW'(p)) begin
          if (cfg_hi) ent_q[p][63:32] <= cfg_wdata;
          else        ent_q[p][31:0]  <= cfg_wdata & ~RO_LO;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= '0;
      rirr_q <= '0;
      prev_q <= '0;
    end else begin
      for (int p = 0; p < NPINS; p++) begin
        if (trig_v[p]) irr_q[p] <= pin_lvl[p];
        else           irr_q[p] <= (irr_q[p] & ~take[p]) | (rise[p] & ~mask_v[p]);
      end
      rirr_q <= ((rirr_q & ~rirr_clr) | (take & trig_v)) & trig_nx;
      prev_q <= pin_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (load) begin
      msg_valid <= 1'b1;
      msg_addr  <= MSG_BASE | {12'd0, sel_ent[63:48], 4'd0}
                            | {29'd0, sel_ent[BIT_DMODE], 2'd0};
      msg_data  <= {16'd0, sel_ent[BIT_TRIG], 4'd0, sel_ent[10:8], vec};
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end
endmodule

module irq_redir_engine_chk #(
  parameter int NPINS = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [31:0]      msg_addr,
  input logic [31:0]      msg_data,
  input logic [NPINS-1:0] rirr
);
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  p_addr_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_addr[31:20] == 12'hFEE && !msg_addr[3] && msg_addr[1:0] == 2'b00);

  p_data_layout_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_data[31:16] == 16'd0 && msg_data[14:11] == 4'd0);

  p_one_rirr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rirr & ~$past(rirr)) <= 1);

  p_rirr_with_msg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rirr & ~$past(rirr))) |-> msg_valid);
endmodule

bind irq_redir_engine irq_redir_engine_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data), .rirr(rirr_q)
);

// File: tb/irq_redir_engine_test.sv
module irq_redir_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic        cfg_we = 1'b0, cfg_hi = 1'b0;
  logic [4:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [23:0] rirr_clr = '0;
  logic [7:0]  ext_vector = '0;
  logic        msg_valid, msg_ready = 1'b1;
  logic [31:0] msg_addr, msg_data;

  irq_redir_engine uut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .cfg_we(cfg_we),
    .cfg_hi(cfg_hi), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .rirr_clr(rirr_clr), .ext_vector(ext_vector),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_data(msg_data)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int cnt [24];
  logic [31:0] last_a [24];
  logic [31:0] last_d [24];
  int ord [$];

  logic [63:0] m_ent [24];
  bit [23:0] m_irr, m_rirr, m_prev;
  bit m_v;
  logic [31:0] m_a, m_d;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit [23:0] lv, nirr, nrirr, tk, tv;
    int s;
    logic [63:0] e;
    logic [7:0] vec;
    if (!rst_n) begin
      for (int p = 0; p < 24; p++) m_ent[p] = 64'h1_0000;
      m_irr = '0; m_rirr = '0; m_prev = '0; m_v = 1'b0; m_a = '0; m_d = '0;
    end else begin
      for (int p = 0; p < 24; p++) begin
        lv[p] = (p == 0) ? 1'b0 : (p == 2) ? (irq_lines[0] | irq_lines[2]) : irq_lines[p];
        tv[p] = m_ent[p][15];
      end
      s = -1;
      for (int p = 23; p >= 0; p--)
        if (m_irr[p] && !m_ent[p][16] && !(m_ent[p][15] && m_rirr[p])) s = p;
      tk = '0;
      if (s >= 0 && (!m_v || msg_ready)) begin
        tk[s] = 1'b1;
        e = m_ent[s];
        vec = (e[10:8] == 3'd7) ? ext_vector : e[7:0];
        m_a = 32'hFEE0_0000 | (32'(e[63:48]) << 4) | (32'(e[11]) << 2);
        m_d = 32'(vec) | (32'(e[10:8]) << 8) | (32'(e[15]) << 15);
        m_v = 1'b1;
      end else if (msg_ready) m_v = 1'b0;
      for (int p = 0; p < 24; p++)
        nirr[p] = m_ent[p][15] ? lv[p]
                : ((m_irr[p] && !tk[p]) || (lv[p] && !m_prev[p] && !m_ent[p][16]));
      nrirr = (m_rirr & ~rirr_clr) | (tk & tv);
      if (cfg_we && cfg_idx < 24) begin
        if (cfg_hi) m_ent[cfg_idx][63:32] = cfg_wdata;
        else        m_ent[cfg_idx][31:0]  = cfg_wdata & ~32'h5000;
      end
      for (int p = 0; p < 24; p++) if (!m_ent[p][15]) nrirr[p] = 1'b0;
      m_irr = nirr; m_rirr = nrirr; m_prev = lv;
    end
  end

  always @(posedge clk) begin
    if (rst_n && msg_valid && msg_ready && msg_addr[19:4] < 24) begin
      cnt[msg_addr[19:4]]++;
      last_a[msg_addr[19:4]] = msg_addr;
      last_d[msg_addr[19:4]] = msg_data;
      ord.push_back(int'(msg_addr[19:4]));
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(msg_valid == m_v, "R10 valid vs model", 64'(msg_valid), 64'(m_v));
      if (m_v) begin
        chk(msg_addr == m_a, "R7 addr vs model", 64'(msg_addr), 64'(m_a));
        chk(msg_data == m_d, "R8 data vs model", 64'(msg_data), 64'(m_d));
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int idx, bit hi, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_hi = hi; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rdchk(int idx, bit hi, logic [31:0] exp, string tag);
    @(negedge clk);
    cfg_idx = 5'(idx); cfg_hi = hi;
    #1;
    chk(cfg_rdata == exp, tag, 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic setup(int p, logic [7:0] v, logic [2:0] dm, bit dmode, bit lvl, bit msk);
    wr(p, 1'b1, 32'(p) << 16);
    wr(p, 1'b0, 32'(v) | (32'(dm) << 8) | (32'(dmode) << 11) | (32'(lvl) << 15) | (32'(msk) << 16));
  endtask

  task automatic pulse(int line);
    @(negedge clk); irq_lines[line] = 1'b1;
    @(negedge clk); irq_lines[line] = 1'b0;
  endtask

  task automatic clr_pulse(int p);
    @(negedge clk); rirr_clr[p] = 1'b1;
    @(negedge clk); rirr_clr[p] = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog R10 act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int tot, c9;
    logic [31:0] held;
    for (int p = 0; p < 24; p++) cnt[p] = 0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    rdchk(0, 1'b0, 32'h0001_0000, "R1 entry0 low");
    rdchk(23, 1'b0, 32'h0001_0000, "R1 entry23 low");
    rdchk(5, 1'b1, 32'h0, "R1 entry5 high");
    chk(msg_valid == 1'b0, "R1 no message", 64'(msg_valid), 64'd0);

    setup(2, 8'h22, 3'd0, 1'b0, 1'b0, 1'b0);
    setup(3, 8'h23, 3'd0, 1'b0, 1'b0, 1'b1);
    setup(4, 8'h24, 3'd0, 1'b1, 1'b0, 1'b0);
    setup(5, 8'h25, 3'd0, 1'b0, 1'b0, 1'b0);
    setup(7, 8'h27, 3'd7, 1'b0, 1'b0, 1'b0);
    setup(9, 8'h29, 3'd0, 1'b0, 1'b1, 1'b0);
    setup(11, 8'h2B, 3'd0, 1'b0, 1'b1, 1'b1);
    tick(4);

    // R5 edge delivery, one message per edge
    pulse(5); tick(5);
    chk(cnt[5] == 1, "R5 single edge", 64'(cnt[5]), 64'd1);
    @(negedge clk); irq_lines[5] = 1'b1; tick(8); irq_lines[5] = 1'b0; tick(4);
    chk(cnt[5] == 2, "R5 long high one message", 64'(cnt[5]), 64'd2);

    // R2 remap and ignored lines
    pulse(0); tick(5);
    chk(cnt[2] == 1, "R2 line0 to pin2", 64'(cnt[2]), 64'd1);
    tot = ord.size();
    pulse(24); pulse(26); pulse(31); tick(5);
    chk(ord.size() == tot, "R2 high lines ignored", 64'(ord.size()), 64'(tot));

    // R4 masked edge discarded
    pulse(3); tick(5);
    wr(3, 1'b0, 32'h23); tick(6);
    chk(cnt[3] == 0, "R4 masked edge dropped", 64'(cnt[3]), 64'd0);
    pulse(3); tick(5);
    chk(cnt[3] == 1, "R4 unmasked edge", 64'(cnt[3]), 64'd1);

    // R3 level delivery and remote-request hold
    @(negedge clk); irq_lines[9] = 1'b1; tick(6);
    chk(cnt[9] == 1, "R3 level delivered", 64'(cnt[9]), 64'd1);
    rdchk(9, 1'b0, 32'h0000_C029, "R3 remote flag set");
    tick(8);
    chk(cnt[9] == 1, "R3 held while flag set", 64'(cnt[9]), 64'd1);
    chk(last_d[9] == 32'h0000_8029, "R8 level data", 64'(last_d[9]), 64'h8029);
    chk(last_a[9] == 32'hFEE0_0090, "R7 level addr", 64'(last_a[9]), 64'hFEE00090);

    // R11 clear redelivers while asserted
    clr_pulse(9); tick(6);
    chk(cnt[9] == 2, "R11 redelivery", 64'(cnt[9]), 64'd2);
    @(negedge clk); irq_lines[9] = 1'b0; tick(2);
    clr_pulse(9); tick(4);
    chk(cnt[9] == 2, "R11 no redelivery when low", 64'(cnt[9]), 64'd2);
    rdchk(9, 1'b0, 32'h0000_8029, "R11 flag cleared");

    // R11 clear and delivery in the same cycle: flag stays set
    @(negedge clk); irq_lines[9] = 1'b1;
    @(negedge clk); rirr_clr[9] = 1'b1;
    @(negedge clk); rirr_clr[9] = 1'b0;
    tick(6);
    chk(cnt[9] == 3, "R11 same-cycle delivery", 64'(cnt[9]), 64'd3);
    rdchk(9, 1'b0, 32'h0000_C029, "R11 set wins over clear");
    tick(6);
    chk(cnt[9] == 3, "R11 no extra message", 64'(cnt[9]), 64'd3);

    // R12 read-only bits and edge switch
    wr(9, 1'b0, 32'h0000_9029); tick(1);
    rdchk(9, 1'b0, 32'h0000_C029, "R12 bits 12/14 read-only");
    wr(9, 1'b0, 32'h0000_0029); tick(1);
    rdchk(9, 1'b0, 32'h0000_0029, "R12 edge write clears flag");
    tick(4);
    c9 = cnt[9];
    wr(9, 1'b0, 32'h0000_8029); tick(6);
    chk(cnt[9] == c9 + 1, "R12 level again redelivers", 64'(cnt[9]), 64'(c9 + 1));
    wr(9, 1'b1, 32'h0009_ABCD);
    rdchk(9, 1'b1, 32'h0009_ABCD, "R12 upper half write");
    rdchk(9, 1'b0, 32'h0000_C029, "R12 lower half untouched");
    @(negedge clk); irq_lines[9] = 1'b0; tick(2);
    clr_pulse(9); tick(3);

    // R6 masked level stays pending
    @(negedge clk); irq_lines[11] = 1'b1; tick(6);
    chk(cnt[11] == 0, "R6 masked no message", 64'(cnt[11]), 64'd0);
    wr(11, 1'b0, 32'h0000_802B); tick(6);
    chk(cnt[11] == 1, "R6 unmask delivers", 64'(cnt[11]), 64'd1);
    @(negedge clk); irq_lines[11] = 1'b0;
    clr_pulse(11); tick(3);

    // R9 external vector
    @(negedge clk); ext_vector = 8'h5A;
    pulse(7); tick(5);
    chk(last_d[7] == 32'h0000_075A, "R9 ext vector", 64'(last_d[7]), 64'h75A);

    // R7/R8 destination mode
    pulse(4); tick(5);
    chk(last_a[4] == 32'hFEE0_0044, "R7 dest mode addr", 64'(last_a[4]), 64'hFEE00044);
    chk(last_d[4] == 32'h0000_0024, "R8 edge data", 64'(last_d[4]), 64'h24);

    // R10 priority and stall
    ord.delete();
    @(negedge clk); msg_ready = 1'b0; irq_lines[5] = 1'b1; irq_lines[4] = 1'b1;
    @(negedge clk); irq_lines[5] = 1'b0; irq_lines[4] = 1'b0;
    tick(4);
    chk(msg_valid == 1'b1, "R10 valid under stall", 64'(msg_valid), 64'd1);
    chk(msg_addr == 32'hFEE0_0044, "R10 lowest first", 64'(msg_addr), 64'hFEE00044);
    held = msg_addr;
    tick(3);
    chk(msg_addr == held, "R10 held stable", 64'(msg_addr), 64'(held));
    @(negedge clk); msg_ready = 1'b1;
    tick(5);
    chk(ord.size() == 2, "R10 two messages", 64'(ord.size()), 64'd2);
    if (ord.size() == 2) begin
      chk(ord[0] == 4, "R10 order first", 64'(ord[0]), 64'd4);
      chk(ord[1] == 5, "R10 order second", 64'(ord[1]), 64'd5);
    end

    tick(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule